// File: doc/BRIEF.md
# Forward 8x8 Two-Dimensional DCT Engine

This block transforms one 8x8 tile of signed picture samples into 64 frequency coefficients. Each tile holds a single colour component: luma, or one of the two chroma differences. Samples arrive one per clock over a valid/ready handshake, in raster order. Each sample is a two's complement value whose offset has already been removed. The engine applies an 8-point transform along each row of the tile, then along each column. A per-tile precision flag chooses between 9-bit and 8-bit signed input, and both precisions use the same arithmetic.

Row results keep three fractional bits. They go into a two-bank corner-turn store, so one tile can be loaded while the previous tile is read out column by column. The result is a sustained rate of one sample per clock in and one coefficient per clock out. Coefficients leave in raster order of frequency as 12-bit signed values. A start marker accompanies the DC term. Output backpressure stalls the loading side only when both banks hold unread tiles.

Top module: `fdct8x8_engine`

## Requirements
- R1: While a bank is free, `in_ready` stays high and a tile of 64 samples is accepted in 64 consecutive cycles, row by row, eight samples per row.
- R2: With `in_mode8` low, every coefficient is within ±1 LSB of F(u,v) = ¼·c(u)·c(v)·Σy Σx f(y,x)·cos((2x+1)vπ/16)·cos((2y+1)uπ/16), where c(0)=1/√2 and c(k)=1 otherwise, and the full 9-bit sample is the value of f.
- R3: With `in_mode8` high, bits [7:0] of each sample are taken as an 8-bit two's complement value and sign-extended, and bit 8 has no effect on any coefficient.
- R4: The precision is taken from `in_mode8` on the first accepted sample of a tile and holds for the whole tile. Changes on later samples of that tile have no effect.
- R5: The 64 coefficients of a tile leave in the order u·8+v, where u is the vertical frequency and v the horizontal frequency.
- R6: `out_sob` is high together with the DC coefficient (u=0, v=0) of each tile and low with every other coefficient.
- R7: When the output side is idle, the DC coefficient is valid in the cycle after the clock edge that accepts the 64th sample.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_coef` and `out_sob` hold their values.
- R9: A second tile is accepted without a stall while the first is still unread. `in_ready` falls only when both banks hold unread tiles.
- R10: Coefficients are rounded to nearest and clipped to [-2048, 2047]. A tile of all -256 gives a DC term of exactly -2048.
- R11: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Engine can take a sample |
| in_sample | input | 9 | Signed sample, raster order |
| in_mode8 | input | 1 | 1 = 8-bit signed input, read on the first sample of a tile |
| out_valid | output | 1 | Coefficient present |
| out_ready | input | 1 | Consumer takes the coefficient |
| out_coef | output | 12 | Signed coefficient |
| out_sob | output | 1 | Marks the DC coefficient of a tile |

## Verification
The DC term of a tile is due in the cycle after its 64th sample is taken, provided the output side is idle. Each later coefficient is due one accepted output handshake after the previous one. Nothing is due while `out_ready` is low. The driver task computes the ideal coefficients in floating point when it issues a tile and queues them in output order. The monitor samples one nanosecond after each falling edge and pops exactly one expected item for every cycle in which both `out_valid` and `out_ready` are high, so the checks follow the handshake timing rather than a fixed delay. The latency, backpressure and bank-full checks sample at those same points, counting the registers on the path.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int N       = 8;
    localparam int NLOG    = 3;
    localparam int COEF_W  = 14;
    localparam int COEF_FRAC = 13;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef struct packed {
        logic            wr_bank;
        logic            rd_bank;
        logic [1:0]      full;
        logic [NLOG-1:0] in_row;
        logic [NLOG-1:0] in_col;
        logic            mode8;
        logic [NLOG-1:0] out_u;
        logic [NLOG-1:0] out_v;
    } ctl_t;

    // cos(m*pi/16) scaled by 2^12, i.e. 0.5*cos scaled by 2^COEF_FRAC
    function automatic coef_t cos_q(input int m);
        int  r;
        int  v;
        bit  neg;
        r   = m % 32;
        if (r > 16) r = 32 - r;
        neg = 1'b0;
        if (r > 8) begin
            r   = 16 - r;
            neg = 1'b1;
        end
        case (r)
            0:       v = 4096;
            1:       v = 4017;
            2:       v = 3784;
            3:       v = 3406;
            4:       v = 2896;
            5:       v = 2276;
            6:       v = 1567;
            7:       v = 799;
            default: v = 0;
        endcase
        return coef_t'(neg ? -v : v);
    endfunction

    // basis weight for frequency k at position n, orthonormal scaling
    function automatic coef_t basis(input int k, input int n);
        if (k == 0) return coef_t'(2896);
        return cos_q((2 * n + 1) * k);
    endfunction

endpackage

// File: rtl/dct_row_pass.sv
module dct_row_pass
    import dct_pkg::*;
#(
    parameter int IN_W     = 9,
    parameter int ROW_FRAC = 3,
    parameter int ROW_W    = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fire,
    input  logic [NLOG-1:0]               col,
    input  logic signed [IN_W-1:0]        sample,
    output logic [N-1:0][ROW_W-1:0]       row_vals,
    output logic                          row_done
);

    localparam int ACC_W = IN_W + COEF_W + NLOG;
    localparam int SHIFT = COEF_FRAC - ROW_FRAC;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SHIFT - 1);

    typedef struct packed {
        logic [N-1:0][ACC_W-1:0] acc;
    } row_st_t;

    row_st_t st_d, st_q;

    logic signed [ACC_W-1:0] sx;
    logic signed [ACC_W-1:0] cf   [N];
    logic signed [ACC_W-1:0] base [N];
    logic signed [ACC_W-1:0] sum  [N];
    logic signed [ACC_W-1:0] rnd  [N];

    // every sample feeds all N frequency accumulators at once (R1)
    always_comb begin
        st_d = st_q;
        sx   = ACC_W'(sample);
        for (int k = 0; k < N; k++) begin
            cf[k]   = ACC_W'(basis(k, int'(col)));
            base[k] = (col == '0) ? '0 : $signed(st_q.acc[k]);
            sum[k]  = base[k] + sx * cf[k];
            if (fire) st_d.acc[k] = sum[k];
            rnd[k]      = (sum[k] + HALF) >>> SHIFT;
            row_vals[k] = ROW_W'(rnd[k]);
        end
        row_done = fire && (col == NLOG'(N - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dct_xpose_buf.sv
module dct_xpose_buf
    import dct_pkg::*;
#(
    parameter int ROW_W = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [NLOG-1:0]          wr_row,
    input  logic [N-1:0][ROW_W-1:0]  wr_vals,
    input  logic                     rd_bank,
    input  logic [NLOG-1:0]          rd_col,
    output logic [N-1:0][ROW_W-1:0]  rd_vals
);

    typedef struct packed {
        logic [1:0][N-1:0][N-1:0][ROW_W-1:0] mem;
    } buf_st_t;

    buf_st_t st_d, st_q;

    // a whole row of results lands in one cycle
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int k = 0; k < N; k++) begin
                st_d.mem[wr_bank][wr_row][k] = wr_vals[k];
            end
        end
    end

    // a whole column is read out in one cycle (corner turn)
    always_comb begin
        for (int y = 0; y < N; y++) begin
            rd_vals[y] = st_q.mem[rd_bank][y][rd_col];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dct_col_pass.sv
module dct_col_pass
    import dct_pkg::*;
#(
    parameter int ROW_W    = 15,
    parameter int ROW_FRAC = 3,
    parameter int OUT_W    = 12
) (
    input  logic [N-1:0][ROW_W-1:0]  col_vals,
    input  logic [NLOG-1:0]          u,
    output logic [OUT_W-1:0]         coef
);

    localparam int CACC_W = ROW_W + COEF_W + NLOG;
    localparam int SHIFT  = COEF_FRAC + ROW_FRAC;
    localparam logic signed [CACC_W-1:0] HALF = CACC_W'(1) <<< (SHIFT - 1);
    localparam longint MAXV = (longint'(1) << (OUT_W - 1)) - 1;
    localparam longint MINV = -(longint'(1) << (OUT_W - 1));

    logic signed [CACC_W-1:0] term [N];
    logic signed [CACC_W-1:0] sum;
    logic signed [CACC_W-1:0] rnd;
    longint                   wide;

    // R10: round to nearest, then clip to the output range
    always_comb begin
        sum = '0;
        for (int y = 0; y < N; y++) begin
            term[y] = CACC_W'($signed(col_vals[y])) * CACC_W'(basis(int'(u), y));
            sum     = sum + term[y];
        end
        rnd  = (sum + HALF) >>> SHIFT;
        wide = longint'(rnd);
        if (wide > MAXV)      coef = OUT_W'(MAXV);
        else if (wide < MINV) coef = OUT_W'(MINV);
        else                  coef = OUT_W'(rnd);
    end

endmodule

// File: rtl/fdct8x8_engine.sv
module fdct8x8_engine
    import dct_pkg::*;
#(
    parameter int IN_W     = 9,
    parameter int OUT_W    = 12,
    parameter int ROW_FRAC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_sample,
    input  logic             in_mode8,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_coef,
    output logic             out_sob
);

    localparam int ROW_W = IN_W + ROW_FRAC + NLOG;
    localparam logic [NLOG-1:0] LAST = NLOG'(N - 1);

    ctl_t st_d, st_q;

    logic                     in_fire;
    logic                     out_fire;
    logic                     first_smp;
    logic                     mode_eff;
    logic signed [IN_W-1:0]   sample_x;
    logic [N-1:0][ROW_W-1:0]  row_vals;
    logic                     row_done;
    logic [N-1:0][ROW_W-1:0]  col_vals;
    logic                     blk_in_done;
    logic                     blk_out_done;

    always_comb begin
        st_d = st_q;

        // R9: loading stalls only when the bank being filled is still unread
        in_ready  = !st_q.full[st_q.wr_bank];
        in_fire   = in_valid && in_ready;
        out_valid = st_q.full[st_q.rd_bank];
        out_fire  = out_valid && out_ready;
        out_sob   = out_valid && (st_q.out_u == '0) && (st_q.out_v == '0);

        // R4: precision read on the first sample, held for the tile
        first_smp = (st_q.in_row == '0) && (st_q.in_col == '0);
        mode_eff  = first_smp ? in_mode8 : st_q.mode8;
        // R3: 8-bit mode sign-extends the low byte
        sample_x  = mode_eff ? {{(IN_W - 8){in_sample[7]}}, in_sample[7:0]}
                             : $signed(in_sample);

        blk_in_done  = in_fire && (st_q.in_row == LAST) && (st_q.in_col == LAST);
        blk_out_done = out_fire && (st_q.out_u == LAST) && (st_q.out_v == LAST);

        if (in_fire) begin
            if (first_smp) st_d.mode8 = in_mode8;
            st_d.in_col = st_q.in_col + 1'b1;
            if (st_q.in_col == LAST) st_d.in_row = st_q.in_row + 1'b1;
        end
        if (blk_in_done) begin
            st_d.full[st_q.wr_bank] = 1'b1;
            st_d.wr_bank            = ~st_q.wr_bank;
        end

        // R5: raster order over (u, v)
        if (out_fire) begin
            st_d.out_v = st_q.out_v + 1'b1;
            if (st_q.out_v == LAST) st_d.out_u = st_q.out_u + 1'b1;
        end
        if (blk_out_done) begin
            st_d.full[st_q.rd_bank] = 1'b0;
            st_d.rd_bank            = ~st_q.rd_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dct_row_pass #(
        .IN_W     (IN_W),
        .ROW_FRAC (ROW_FRAC),
        .ROW_W    (ROW_W)
    ) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (in_fire),
        .col      (st_q.in_col),
        .sample   (sample_x),
        .row_vals (row_vals),
        .row_done (row_done)
    );

    dct_xpose_buf #(
        .ROW_W (ROW_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (row_done),
        .wr_bank (st_q.wr_bank),
        .wr_row  (st_q.in_row),
        .wr_vals (row_vals),
        .rd_bank (st_q.rd_bank),
        .rd_col  (st_q.out_v),
        .rd_vals (col_vals)
    );

    dct_col_pass #(
        .ROW_W    (ROW_W),
        .ROW_FRAC (ROW_FRAC),
        .OUT_W    (OUT_W)
    ) u_col (
        .col_vals (col_vals),
        .u        (st_q.out_u),
        .coef     (out_coef)
    );

endmodule

// File: rtl/fdct8x8_engine_chk.sv
module fdct8x8_engine_chk #(
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_sob,
    input logic [OUT_W-1:0] out_coef
);

    // R8
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_coef) && $stable(out_sob));

    // R6
    sob_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sob |-> out_valid);

    // R6
    sob_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_sob |=> !out_sob);

    // R9
    stall_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);

    // R11
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && in_ready);

endmodule

bind fdct8x8_engine fdct8x8_engine_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sob   (out_sob),
    .out_coef  (out_coef)
);

// File: tb/fdct8x8_engine_bench.sv
`timescale 1ns/100ps
module fdct8x8_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [8:0]  in_sample = '0;
    logic        in_mode8 = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [11:0] out_coef;
    logic        out_sob;

    int checks = 0;
    int errors = 0;
    int seen   = 0;

    real   exp_q [$];
    bit    sob_q [$];
    string tag_q [$];

    always #2.5 clk = ~clk;

    fdct8x8_engine u_fdct8x8_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sample (in_sample),
        .in_mode8  (in_mode8),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_coef  (out_coef),
        .out_sob   (out_sob)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic real cs(input int k, input int n);
        if (k == 0) return $sqrt(0.125);
        return 0.5 * $cos((2.0 * n + 1.0) * k * 3.14159265358979 / 16.0);
    endfunction

    task automatic push_expected(input int f [64], input string tag);
        for (int u = 0; u < 8; u++) begin
            for (int v = 0; v < 8; v++) begin
                real acc;
                acc = 0.0;
                for (int y = 0; y < 8; y++)
                    for (int x = 0; x < 8; x++)
                        acc += cs(u, y) * cs(v, x) * f[y * 8 + x];
                if (acc > 2047.0)  acc = 2047.0;
                if (acc < -2048.0) acc = -2048.0;
                exp_q.push_back(acc);
                sob_q.push_back(u == 0 && v == 0);
                tag_q.push_back(tag);
            end
        end
    endtask

    // raw values are in -256..255; toggle flips in_mode8 after the first sample
    task automatic send_block(input int raw [64], input bit mode8, input bit toggle,
                              input string tag, input bit chk_lat, output int stalls);
        int f [64];
        for (int i = 0; i < 64; i++) begin
            if (mode8) begin
                f[i] = raw[i] & 255;
                if (f[i] >= 128) f[i] -= 256;
            end else begin
                f[i] = raw[i];
            end
        end
        push_expected(f, tag);
        stalls = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 9'(raw[i]);
            in_mode8  = (toggle && i > 0) ? ~mode8 : mode8;
            #1;
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (chk_lat) begin
            #1;
            // R7: DC due one cycle after the 64th sample edge
            check(out_valid && out_sob, "R7", "DC not valid after last sample",
                  int'(out_valid && out_sob), 1);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected coefficient", int'($signed(out_coef)), 0);
                end else begin
                    real   e;
                    bit    s;
                    string t;
                    int    got;
                    real   diff;
                    e    = exp_q.pop_front();
                    s    = sob_q.pop_front();
                    t    = tag_q.pop_front();
                    got  = int'($signed(out_coef));
                    diff = got - e;
                    if (diff < 0.0) diff = -diff;
                    check(diff <= 1.0, t, $sformatf("coef %0d off by more than 1 LSB", seen % 64),
                          got, int'(e));
                    check(out_sob == s, "R6", "start marker", int'(out_sob), int'(s));
                    if (t == "R10" && s)
                        check(got == -2048, "R10", "extreme DC exact", got, -2048);
                    seen++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int blk  [64];
        int blk2 [64];
        int st;
        int st2;
        logic [11:0] held;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11
        check(in_ready == 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);

        // R2 / R1 / R7: random 9-bit tile
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(511)) - 256;
        send_block(blk, 1'b0, 1'b0, "R2", 1'b1, st);
        check(st == 0, "R1", "stalls on idle engine", st, 0);
        drain();

        // R5: asymmetric ramp distinguishes row and column order
        for (int i = 0; i < 64; i++) blk[i] = 24 * (i % 8) - 7 * (i / 8) - 40;
        send_block(blk, 1'b0, 1'b0, "R5", 1'b0, st);
        drain();

        // R3: 8-bit mode with noise on bit 8
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(511)) - 256;
        send_block(blk, 1'b1, 1'b0, "R3", 1'b0, st);
        drain();

        // R4: 8-bit tile, mode pin flipped after the first sample
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(511)) - 256;
        send_block(blk, 1'b1, 1'b1, "R4", 1'b0, st);
        drain();

        // R10: extreme negative tile
        for (int i = 0; i < 64; i++) blk[i] = -256;
        send_block(blk, 1'b0, 1'b0, "R10", 1'b0, st);
        drain();

        // R9: two tiles loaded with the output blocked
        out_ready = 1'b0;
        for (int i = 0; i < 64; i++) blk[i]  = int'($urandom_range(511)) - 256;
        for (int i = 0; i < 64; i++) blk2[i] = int'($urandom_range(511)) - 256;
        send_block(blk, 1'b0, 1'b0, "R9", 1'b0, st);
        send_block(blk2, 1'b0, 1'b0, "R9", 1'b0, st2);
        check(st + st2 == 0, "R9", "stalls while a bank was free", st + st2, 0);
        @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R9", "in_ready with both banks full", int'(in_ready), 0);

        // R8: stall mid-stream
        @(negedge clk);
        out_ready = 1'b1;
        repeat (10) @(negedge clk);
        out_ready = 1'b0;
        @(negedge clk);
        #1;
        held = out_coef;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            #1;
            check(out_valid && out_coef == held, "R8", "output moved under stall",
                  int'($signed(out_coef)), int'($signed(held)));
        end
        out_ready = 1'b1;
        drain();

        check(out_valid == 1'b0, "R9", "output idle after both tiles", int'(out_valid), 0);
        check(seen == 7 * 64, "R5", "coefficient count", seen, 7 * 64);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule